// File: doc/BRIEF.md
# Event Timer Global Registers and Main Counter

This block is the shared core of a multi-channel event timer. It holds a read-only capability word, a two-bit global configuration register, a per-channel interrupt status register cleared by writing ones, and a 64-bit main counter. The counter advances once for every tick-enable pulse while counting is enabled. The comparator channels sit outside this block. They receive the live counter value, the global enable level and the legacy-routing flag, and they raise status bits through a set input.

Software reaches the block over a simple register bus. A request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a write flag and 64 bits of write data. Read data comes back one cycle later. A naturally aligned 8-byte read returns two adjacent 32-bit words taken from a single cycle. A 64-bit counter read therefore cannot mix halves from either side of a carry. An 8-byte request that is not aligned to 8 bytes raises an error pulse and does nothing else. Requests of 1 or 2 bytes, and 4-byte requests that are not word aligned, do nothing and raise no error.

Top module: `evtg_top`

## Requirements
- R1: After a synchronous reset, the configuration, status and main counter are all zero, and `count_enable` and `legacy_mode` are low.
- R2: The word at 0x000 reads as: revision 1 in bits [7:0], the number of channels minus one in bits [12:8], bit 13 set (64-bit counter), and bit 15 set (legacy routing available). All other bits of that word are zero. The word at 0x004 holds the tick period in femtoseconds, 69841279 by default. Writes to either word have no effect.
- R3: At 0x010, only bits [1:0] are writable and the other bits read zero. Bit 0 drives `count_enable` and bit 1 drives `legacy_mode`. The word at 0x014 reads zero and ignores writes.
- R4: While bit 0 of the configuration is set, the counter increases by exactly one on each cycle with `tick_en` high. While that bit is clear, the counter holds its value.
- R5: A write to 0x0F0 replaces only counter bits [31:0], and a write to 0x0F4 replaces only bits [63:32]. An aligned 8-byte write at 0x0F0 replaces both halves. A write cycle takes priority over a tick in that cycle.
- R6: A high bit i of `irq_set` sets status bit i, which reads at bit i of 0x020. A write to 0x020 clears each status bit written as one and keeps every other bit. If a set and a clear reach the same bit in the same cycle, the set wins.
- R7: Writes to 0x024, including the upper half of an 8-byte write at 0x020, leave the status unchanged. The word at 0x024 reads zero.
- R8: An aligned 8-byte read at 0x0F0 returns the counter value held at the request edge as one 64-bit word, with bits [63:32] in `bus_rdata[63:32]`. This holds even when a tick in that same cycle carries across bit 31.
- R9: An 8-byte request whose address bits [2:0] are not zero raises `bus_err` for one cycle. A read of this kind returns zero, and a write of this kind changes no state.
- R10: A 1-byte or 2-byte request, and a 4-byte request whose address bits [1:0] are not zero, change no state, read back zero, and raise no error.
- R11: A 4-byte read at any offset other than 0x000, 0x004, 0x010, 0x014, 0x020, 0x024, 0x0F0 and 0x0F4 returns zero. A write to any such offset has no effect.
- R12: `bus_rvalid` is high for exactly the cycle after each read request of any size, and stays low after a write request. A 4-byte read returns its word in `bus_rdata[31:0]` with the upper half zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One pulse per counter tick period |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data, low word to the addressed word |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_err | output | 1 | Misaligned 8-byte request flag |
| irq_set | input | NUM_TIMERS | Per-channel status set pulses |
| main_count | output | 64 | Live main counter value to the channels |
| count_enable | output | 1 | Global counter and interrupt enable |
| legacy_mode | output | 1 | Legacy routing selection |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check matters. They also assume that `irq_set`, `tick_en` and the bus signals are stable around each rising edge. The bench keeps to this by changing every input on the falling edge and holding it for one full cycle. All request sizes, aligned and misaligned, are legal inputs for the assertions. The bench drives each kind on purpose, together with full sweeps of status set and clear patterns and of every word offset in the decoded space.

// File: rtl/evtg_pkg.sv
package evtg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int unsigned OFF_CAP    = 32'h000;
  localparam int unsigned OFF_PERIOD = 32'h004;
  localparam int unsigned OFF_CFG    = 32'h010;
  localparam int unsigned OFF_CFG_HI = 32'h014;
  localparam int unsigned OFF_STAT   = 32'h020;
  localparam int unsigned OFF_STAT_HI= 32'h024;
  localparam int unsigned OFF_CNT_LO = 32'h0F0;
  localparam int unsigned OFF_CNT_HI = 32'h0F4;

  localparam int unsigned PERIOD_SLOW_FS = 32'd69841279;
  localparam int unsigned PERIOD_FAST_FS = 32'd10000000;

  function automatic logic [31:0] cap_low_word(input int unsigned n_chan,
                                               input int unsigned rev);
    logic [31:0] w;
    w        = '0;
    w[7:0]   = rev[7:0];
    w[12:8]  = 5'(n_chan - 1);
    w[13]    = 1'b1;
    w[15]    = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/evtg_decode.sv
module evtg_decode
  import evtg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_TIMERS = 3
) (
  input  logic                  valid,
  input  logic                  write,
  input  logic [1:0]            size,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [63:0]           wdata,
  output logic [ADDR_W-1:0]     a_lo,
  output logic [ADDR_W-1:0]     a_hi,
  output logic                  rd_req,
  output logic                  rd_w4,
  output logic                  rd_w8,
  output logic                  misalign,
  output logic                  we_cfg,
  output logic [1:0]            d_cfg,
  output logic                  we_stat,
  output logic [NUM_TIMERS-1:0] d_stat,
  output logic                  we_clo,
  output logic [31:0]           d_clo,
  output logic                  we_chi,
  output logic [31:0]           d_chi
);

  logic ok4, ok8, wr_ok;
  logic [32:0] sel_cfg, sel_stat, sel_clo, sel_chi;

  function automatic logic [32:0] route(input logic [ADDR_W-1:0] lo,
                                        input logic [ADDR_W-1:0] hi,
                                        input logic              wide,
                                        input logic              en,
                                        input logic [63:0]       d,
                                        input int unsigned       target);
    logic [ADDR_W-1:0] t;
    t = ADDR_W'(target);
    if (en && lo == t)
      return {1'b1, d[31:0]};
    else if (en && wide && hi == t)
      return {1'b1, d[63:32]};
    else
      return {1'b0, 32'd0};
  endfunction

  always_comb begin
    ok4      = (size == SZ_WORD)  && (addr[1:0] == 2'b00);
    ok8      = (size == SZ_DWORD) && (addr[2:0] == 3'b000);
    misalign = valid && (size == SZ_DWORD) && (addr[2:0] != 3'b000);
    a_lo     = {addr[ADDR_W-1:2], 2'b00};
    a_hi     = a_lo | ADDR_W'(4);
    rd_req   = valid && !write;
    rd_w4    = rd_req && ok4;
    rd_w8    = rd_req && ok8;
    wr_ok    = valid && write && (ok4 || ok8);

    sel_cfg  = route(a_lo, a_hi, ok8, wr_ok, wdata, OFF_CFG);
    sel_stat = route(a_lo, a_hi, ok8, wr_ok, wdata, OFF_STAT);
    sel_clo  = route(a_lo, a_hi, ok8, wr_ok, wdata, OFF_CNT_LO);
    sel_chi  = route(a_lo, a_hi, ok8, wr_ok, wdata, OFF_CNT_HI);

    we_cfg   = sel_cfg[32];
    d_cfg    = sel_cfg[1:0];
    we_stat  = sel_stat[32];
    d_stat   = sel_stat[NUM_TIMERS-1:0];
    we_clo   = sel_clo[32];
    d_clo    = sel_clo[31:0];
    we_chi   = sel_chi[32];
    d_chi    = sel_chi[31:0];
  end

endmodule

// File: rtl/evtg_counter.sv
module evtg_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             we_lo,
  input  logic [CNT_W/2-1:0] d_lo,
  input  logic             we_hi,
  input  logic [CNT_W/2-1:0] d_hi,
  output logic [CNT_W-1:0] count
);

  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (we_lo || we_hi) begin
      count <= {we_hi ? d_hi : count[CNT_W-1:HALF],
                we_lo ? d_lo : count[HALF-1:0]};
    end else if (run && tick) begin
      count <= count + CNT_W'(1);
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !we_lo && !we_hi) |=> (count == $past(count) + CNT_W'(1))); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !we_lo && !we_hi) |=> $stable(count)); // R4
  AST_CNT_HALF: assert property (@(posedge clk) disable iff (rst)
    (we_lo && !we_hi) |=> (count[CNT_W-1:HALF] == $past(count[CNT_W-1:HALF]))); // R5

endmodule

// File: rtl/evtg_status.sv
module evtg_status #(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_TIMERS-1:0] set,
  input  logic                  we,
  input  logic [NUM_TIMERS-1:0] clr,
  output logic [NUM_TIMERS-1:0] status
);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        status[i] <= 1'b0;
      else if (set[i])
        status[i] <= 1'b1;
      else if (we && clr[i])
        status[i] <= 1'b0;
    end

    AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> status[i]); // R6
    AST_STAT_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && !(we && clr[i])) |=> $stable(status[i])); // R6
  end

endmodule

// File: rtl/evtg_top.sv
module evtg_top
  import evtg_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int NUM_TIMERS   = 3,
  parameter int REVISION     = 1,
  parameter bit FAST_PERIOD  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [1:0]            bus_size,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [63:0]           bus_wdata,
  output logic [63:0]           bus_rdata,
  output logic                  bus_rvalid,
  output logic                  bus_err,
  input  logic [NUM_TIMERS-1:0] irq_set,
  output logic [63:0]           main_count,
  output logic                  count_enable,
  output logic                  legacy_mode
);

  localparam logic [31:0] PERIOD_FS = FAST_PERIOD ? PERIOD_FAST_FS : PERIOD_SLOW_FS;
  localparam logic [31:0] CAP_LO    = cap_low_word(NUM_TIMERS, REVISION);

  logic [ADDR_W-1:0]     a_lo, a_hi;
  logic                  rd_req, rd_w4, rd_w8, misalign;
  logic                  we_cfg, we_stat, we_clo, we_chi;
  logic [1:0]            d_cfg;
  logic [NUM_TIMERS-1:0] d_stat;
  logic [31:0]           d_clo, d_chi;
  logic [1:0]            cfg;
  logic [NUM_TIMERS-1:0] status;
  logic [63:0]           rd_next;

  evtg_decode #(.ADDR_W(ADDR_W), .NUM_TIMERS(NUM_TIMERS)) u_dec (
    .valid(bus_valid), .write(bus_write), .size(bus_size), .addr(bus_addr),
    .wdata(bus_wdata), .a_lo(a_lo), .a_hi(a_hi), .rd_req(rd_req),
    .rd_w4(rd_w4), .rd_w8(rd_w8), .misalign(misalign),
    .we_cfg(we_cfg), .d_cfg(d_cfg), .we_stat(we_stat), .d_stat(d_stat),
    .we_clo(we_clo), .d_clo(d_clo), .we_chi(we_chi), .d_chi(d_chi)
  );

  evtg_counter #(.CNT_W(64)) u_cnt (
    .clk(clk), .rst(rst), .run(cfg[0]), .tick(tick_en),
    .we_lo(we_clo), .d_lo(d_clo), .we_hi(we_chi), .d_hi(d_chi),
    .count(main_count)
  );

  evtg_status #(.NUM_TIMERS(NUM_TIMERS)) u_stat (
    .clk(clk), .rst(rst), .set(irq_set), .we(we_stat), .clr(d_stat),
    .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst)
      cfg <= 2'b00;
    else if (we_cfg)
      cfg <= d_cfg;
  end

  assign count_enable = cfg[0];
  assign legacy_mode  = cfg[1];

  function automatic logic [31:0] word_at(input logic [ADDR_W-1:0]     a,
                                          input logic [1:0]            c,
                                          input logic [NUM_TIMERS-1:0] s,
                                          input logic [63:0]           n);
    if (a == ADDR_W'(OFF_CAP))         return CAP_LO;
    else if (a == ADDR_W'(OFF_PERIOD)) return PERIOD_FS;
    else if (a == ADDR_W'(OFF_CFG))    return {30'd0, c};
    else if (a == ADDR_W'(OFF_STAT))   return 32'(s);
    else if (a == ADDR_W'(OFF_CNT_LO)) return n[31:0];
    else if (a == ADDR_W'(OFF_CNT_HI)) return n[63:32];
    else                               return 32'd0;
  endfunction

  always_comb begin
    if (rd_w8)
      rd_next = {word_at(a_hi, cfg, status, main_count),
                 word_at(a_lo, cfg, status, main_count)};
    else if (rd_w4)
      rd_next = {32'd0, word_at(a_lo, cfg, status, main_count)};
    else
      rd_next = 64'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= 64'd0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      bus_err    <= misalign;
      if (rd_req)
        bus_rdata <= rd_next;
    end
  end

  AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid); // R12
  AST_RD_ONLY_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_write)); // R12
  AST_ERR_MISALIGN: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_valid && bus_size == 2'd3 && bus_addr[2:0] != 3'd0)); // R9
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !we_cfg |=> $stable({legacy_mode, count_enable})); // R3

endmodule

// File: tb/tb_evtg_top.sv
module tb_evtg_top;

  localparam int NT = 3;
  localparam logic [31:0] CAP_EXP = 32'h0000_A201;
  localparam logic [31:0] PER_EXP = 32'h0429_B17F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic        bus_err;
  logic [NT-1:0] irq_set = '0;
  logic [63:0] main_count;
  logic        count_enable;
  logic        legacy_mode;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] r_data;
  logic        r_valid;
  logic        r_err;

  always #5 clk = ~clk;

  evtg_top dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .irq_set(irq_set), .main_count(main_count),
    .count_enable(count_enable), .legacy_mode(legacy_mode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [63:0] wd, input bit tk, input logic [NT-1:0] irq);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz;
    bus_wdata = wd; tick_en = tk; irq_set = irq;
    @(posedge clk);
    #1;
    r_data = bus_rdata; r_valid = bus_rvalid; r_err = bus_err;
    bus_valid = 1'b0; tick_en = 1'b0; irq_set = '0;
  endtask

  task automatic wr4(input logic [11:0] a, input logic [31:0] d);
    access(1'b1, a, 2'd2, {32'd0, d}, 1'b0, '0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz);
    access(1'b0, a, sz, 64'd0, 1'b0, '0);
  endtask

  task automatic pulse(input bit tk, input logic [NT-1:0] irq);
    @(negedge clk);
    tick_en = tk; irq_set = irq;
    @(posedge clk);
    #1;
    tick_en = 1'b0; irq_set = '0;
  endtask

  function automatic logic [31:0] exp_word(input logic [11:0] a, input logic [1:0] c,
                                           input logic [NT-1:0] s, input logic [63:0] n);
    case (a)
      12'h000: return CAP_EXP;
      12'h004: return PER_EXP;
      12'h010: return {30'd0, c};
      12'h020: return {29'd0, s};
      12'h0F0: return n[31:0];
      12'h0F4: return n[63:32];
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1 counter", main_count, 64'd0);
    check("R1 enable", {63'd0, count_enable}, 64'd0);
    check("R1 legacy", {63'd0, legacy_mode}, 64'd0);
    rd(12'h010, 2'd3);
    check("R1 cfg/status via 8-byte read", r_data, 64'd0);
    rd(12'h020, 2'd2);
    check("R1 status", r_data, 64'd0);

    for (int a = 0; a < 1024; a += 4) begin
      rd(12'(a), 2'd2);
      check((a < 8) ? "R2 cap sweep" : "R11 offset sweep", r_data,
            {32'd0, exp_word(12'(a), 2'd0, '0, 64'd0)});
      check("R12 rvalid after read", {63'd0, r_valid}, 64'd1);
    end

    wr4(12'h000, 32'hFFFF_FFFF);
    check("R12 no rvalid after write", {63'd0, r_valid}, 64'd0);
    wr4(12'h004, 32'hFFFF_FFFF);
    access(1'b1, 12'h000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    rd(12'h000, 2'd3);
    check("R2 id words read-only", r_data, {PER_EXP, CAP_EXP});

    wr4(12'h008, 32'hFFFF_FFFF);
    wr4(12'h030, 32'hFFFF_FFFF);
    access(1'b1, 12'h100, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    rd(12'h0F0, 2'd3);
    check("R11 undefined writes leave counter", r_data, 64'd0);
    rd(12'h010, 2'd3);
    check("R11 undefined writes leave cfg", r_data, 64'd0);

    wr4(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 2'd2);
    check("R3 cfg readback", r_data, 64'd3);
    check("R3 enable out", {63'd0, count_enable}, 64'd1);
    check("R3 legacy out", {63'd0, legacy_mode}, 64'd1);
    wr4(12'h014, 32'hFFFF_FFFF);
    rd(12'h014, 2'd2);
    check("R3 cfg upper word", r_data, 64'd0);
    wr4(12'h010, 32'h0000_0002);
    check("R3 enable cleared", {63'd0, count_enable}, 64'd0);
    check("R3 legacy kept", {63'd0, legacy_mode}, 64'd1);
    wr4(12'h010, 32'h0);

    wr4(12'h0F0, 32'h1234_5678);
    rd(12'h0F0, 2'd3);
    check("R5 low half write", r_data, 64'h0000_0000_1234_5678);
    wr4(12'h0F4, 32'hCAFE_F00D);
    rd(12'h0F0, 2'd3);
    check("R5 high half write", r_data, 64'hCAFE_F00D_1234_5678);
    access(1'b1, 12'h0F0, 2'd3, 64'h0000_0005_FFFF_FFFF, 1'b0, '0);
    check("R5 8-byte write", main_count, 64'h0000_0005_FFFF_FFFF);
    access(1'b1, 12'h0F0, 2'd2, 64'd7, 1'b1, '0);
    check("R5 write beats tick", main_count, 64'h0000_0005_0000_0007);
    access(1'b1, 12'h0F0, 2'd3, 64'h0000_0005_FFFF_FFFF, 1'b0, '0);

    repeat (5) pulse(1'b1, '0);
    check("R4 disabled hold", main_count, 64'h0000_0005_FFFF_FFFF);
    wr4(12'h010, 32'h1);
    for (int k = 1; k <= 4; k++) begin
      pulse(1'b1, '0);
      check("R4 step per tick", main_count, 64'h0000_0005_FFFF_FFFF + 64'(k));
      pulse(1'b0, '0);
      check("R4 no tick no step", main_count, 64'h0000_0005_FFFF_FFFF + 64'(k));
    end

    access(1'b1, 12'h0F0, 2'd3, 64'h0000_0007_FFFF_FFFF, 1'b0, '0);
    access(1'b0, 12'h0F0, 2'd3, 64'd0, 1'b1, '0);
    check("R8 atomic sample at carry", r_data, 64'h0000_0007_FFFF_FFFF);
    check("R8 carry applied", main_count, 64'h0000_0008_0000_0000);
    rd(12'h0F0, 2'd3);
    check("R8 next read", r_data, 64'h0000_0008_0000_0000);
    wr4(12'h010, 32'h0);
    pulse(1'b1, '0);
    check("R4 halted after disable", main_count, 64'h0000_0008_0000_0000);

    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 8; w++) begin
        wr4(12'h020, 32'h7);
        pulse(1'b0, 3'(s));
        rd(12'h020, 2'd2);
        check("R6 set", r_data, 64'(s));
        wr4(12'h020, 32'(w));
        rd(12'h020, 2'd2);
        check("R6 write-one-clear", r_data, 64'(s & ~w & 7));
      end
    end
    wr4(12'h020, 32'h7);
    access(1'b1, 12'h020, 2'd2, 64'h1, 1'b0, 3'b001);
    rd(12'h020, 2'd2);
    check("R6 set wins", r_data, 64'h1);

    pulse(1'b0, 3'b111);
    wr4(12'h024, 32'hFFFF_FFFF);
    rd(12'h020, 2'd3);
    check("R7 upper status write", r_data, 64'h7);
    access(1'b1, 12'h020, 2'd3, 64'hFFFF_FFFF_0000_0000, 1'b0, '0);
    rd(12'h020, 2'd2);
    check("R7 8-byte upper ignored", r_data, 64'h7);

    rd(12'h0F4, 2'd3);
    check("R9 misaligned read err", {63'd0, r_err}, 64'd1);
    check("R9 misaligned read data", r_data, 64'd0);
    access(1'b1, 12'h0F4, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    check("R9 misaligned write err", {63'd0, r_err}, 64'd1);
    check("R9 misaligned write no effect", main_count, 64'h0000_0008_0000_0000);
    access(1'b1, 12'h00C, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    check("R9 cfg untouched", {62'd0, legacy_mode, count_enable}, 64'd0);
    pulse(1'b0, '0);
    check("R9 err is one cycle", {63'd0, bus_err}, 64'd0);

    access(1'b1, 12'h010, 2'd0, 64'hFF, 1'b0, '0);
    check("R10 byte write no effect", {62'd0, legacy_mode, count_enable}, 64'd0);
    check("R10 no err", {63'd0, r_err}, 64'd0);
    access(1'b1, 12'h0F0, 2'd1, 64'hFFFF, 1'b0, '0);
    check("R10 half write no effect", main_count, 64'h0000_0008_0000_0000);
    access(1'b1, 12'h011, 2'd2, 64'hFFFF_FFFF, 1'b0, '0);
    check("R10 unaligned word write", {62'd0, legacy_mode, count_enable}, 64'd0);
    rd(12'h000, 2'd1);
    check("R10 half read zero", r_data, 64'd0);
    check("R12 rvalid small read", {63'd0, r_valid}, 64'd1);
    rd(12'h005, 2'd2);
    check("R10 unaligned word read zero", r_data, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule